// File: doc/BRIEF.md
# Call Duration Timer

This block keeps the talk time of a telephone call as six cascaded BCD digits in hours.minutes.seconds form. The digits advance by one second on each cycle where a one-cycle 1 Hz enable pulse arrives while the run input is high. All carries are formed in one clock domain, and the pulse acts as a clock enable.

A second six-digit register, the held time, tracks the running time while a call is in progress. A freeze command fixes the held time, so that a display can show the total duration after hangup while the running counter is free to continue. A clear input zeroes both registers and releases the freeze before the next call starts. Dividing the 100 Hz clock down to the 1 Hz pulse, scanning the display and decoding segments are handled elsewhere.

Top module: `call_timer`

## Requirements
- R1: After reset, `live_time` and `held_time` are both all zero.
- R2: On a clock edge where `run` and `tick` are both high and `clear` is low, the running time advances by one second. On any other edge without `clear`, it keeps its value.
- R3: The seconds units digit counts 0 to 9. The seconds tens digit counts 0 to 5. Seconds 59 wrap to 00 and carry one into the minutes.
- R4: The minutes digits follow the same 0–9 and 0–5 ranges. Minutes 59 wrap to 00 and carry one into the hours.
- R5: The hours count in BCD up to the parameter `MAX_HOURS` (default 99). A further second from `MAX_HOURS`:59:59 gives 00:00:00.
- R6: Until a freeze is taken, `held_time` equals `live_time` on every cycle. On the edge where `freeze` is high, `held_time` takes the same value that `live_time` takes on that edge.
- R7: After a freeze, `held_time` keeps its value until `clear`, and a further `freeze` has no effect. `live_time` keeps counting under R2.
- R8: `clear` zeroes both registers and releases the freeze on the next edge, and it overrides `run`, `tick` and `freeze` on that edge.
- R9: Digit packing, from bit 23 down, is: hours tens [23:20], hours units [19:16], minutes tens [15:12], minutes units [11:8], seconds tens [7:4], seconds units [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| run | input | 1 | High while a call is connected |
| freeze | input | 1 | Fix the held time at the current total |
| clear | input | 1 | Synchronous zero of both registers; releases the freeze |
| live_time | output | 24 | Running time, six BCD digits |
| held_time | output | 24 | Held total, six BCD digits |

## Verification
The hardest state to reach from the ports is the hours wrap, which takes (MAX_HOURS+1)×3600 enabled seconds. The bench therefore sets `MAX_HOURS` to 2, drives `tick` and `run` high on every cycle for more than 10800 cycles, and so passes through every seconds, minutes and hours carry, including the wrap to zero. After that, a random mix of `clear`, `freeze`, `run` and `tick` exercises the freeze and release paths, including `clear` and `freeze` on the same edge.

// File: rtl/call_timer.sv
module call_timer #(
  parameter int MAX_HOURS = 99
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        run,
  input  logic        freeze,
  input  logic        clear,
  output logic [23:0] live_time,
  output logic [23:0] held_time
);
  localparam logic [3:0] HT = 4'(MAX_HOURS / 10);
  localparam logic [3:0] HU = 4'(MAX_HOURS % 10);

  logic [3:0] su, st, mu, mt, hu, ht;
  logic [3:0] su_n, st_n, mu_n, mt_n, hu_n, ht_n;
  logic [23:0] held_q;
  logic frozen;

  wire c0 = run & tick;
  wire c1 = c0 & (su == 4'd9);
  wire c2 = c1 & (st == 4'd5);
  wire c3 = c2 & (mu == 4'd9);
  wire c4 = c3 & (mt == 4'd5);
  wire hw = c4 & (ht == HT) & (hu == HU);

  always_comb begin
    su_n = c0 ? (c1 ? 4'd0 : su + 4'd1) : su;
    st_n = c1 ? (c2 ? 4'd0 : st + 4'd1) : st;
    mu_n = c2 ? (c3 ? 4'd0 : mu + 4'd1) : mu;
    mt_n = c3 ? (c4 ? 4'd0 : mt + 4'd1) : mt;
    hu_n = hu;
    ht_n = ht;
    if (hw) begin
      hu_n = 4'd0;
      ht_n = 4'd0;
    end else if (c4) begin
      if (hu == 4'd9) begin
        hu_n = 4'd0;
        ht_n = ht + 4'd1;
      end else begin
        hu_n = hu + 4'd1;
      end
    end
  end

  wire [23:0] live_n = {ht_n, hu_n, mt_n, mu_n, st_n, su_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ht, hu, mt, mu, st, su} <= '0;
      held_q <= '0;
      frozen <= 1'b0;
    end else if (clear) begin
      {ht, hu, mt, mu, st, su} <= '0;
      held_q <= '0;
      frozen <= 1'b0;
    end else begin
      {ht, hu, mt, mu, st, su} <= live_n;
      if (!frozen) held_q <= live_n;
      if (freeze) frozen <= 1'b1;
    end
  end

  assign live_time = {ht, hu, mt, mu, st, su};
  assign held_time = held_q;
endmodule

module call_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        run,
  input logic        freeze,
  input logic        clear,
  input logic [23:0] live_time,
  input logic [23:0] held_time
);
  logic hold_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_seen <= 1'b0;
    else if (clear) hold_seen <= 1'b0;
    else if (freeze) hold_seen <= 1'b1;
  end

  a_r3_r4_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    live_time[3:0] <= 4'd9 && live_time[7:4] <= 4'd5 &&
    live_time[11:8] <= 4'd9 && live_time[15:12] <= 4'd5 &&
    live_time[19:16] <= 4'd9 && live_time[23:20] <= 4'd9);

  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> live_time == 24'd0 && held_time == 24'd0);

  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !(run && tick) |=> $stable(live_time));

  a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && run && tick && live_time[3:0] != 4'd9 |=>
      live_time[3:0] == $past(live_time[3:0]) + 4'd1);

  a_r6_track: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_seen |-> held_time == live_time);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_seen && !clear |=> $stable(held_time));
endmodule

bind call_timer call_timer_chk u_chk (.*);

// File: tb/call_timer_bench.sv
module call_timer_bench;
  localparam int MAXH = 2;
  localparam int MODS = (MAXH + 1) * 3600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, run = 0, freeze = 0, clear = 0;
  logic [23:0] live_time, held_time;
  int n_cmp = 0, n_bad = 0;
  int m_live = 0, m_held = 0;
  bit m_hold = 0;
  bit done = 0;

  always #5 clk = ~clk;

  call_timer #(.MAX_HOURS(MAXH)) u_call_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .freeze(freeze),
    .clear(clear), .live_time(live_time), .held_time(held_time));

  function automatic logic [23:0] to_bcd(int s);
    int h = s / 3600, m = (s / 60) % 60, c = s % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(c / 10), 4'(c % 10)};
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit cl, bit rn, bit tk, bit fz);
    clear = cl; run = rn; tick = tk; freeze = fz;
    if (cl) begin
      m_live = 0; m_held = 0; m_hold = 0;
    end else begin
      if (rn && tk) m_live = (m_live + 1) % MODS;
      if (!m_hold) m_held = m_live;
      if (fz) m_hold = 1;
    end
    @(posedge clk);
    @(negedge clk);
    if (cl) begin
      check("R8 live", live_time, 24'd0);
      check("R8 held", held_time, 24'd0);
    end else begin
      check("R2 R3 R4 R5 R9 live", live_time, to_bcd(m_live));
      check(m_hold ? "R7 held" : "R6 held", held_time, to_bcd(m_held));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    #23;
    check("R1 live", live_time, 24'd0);
    check("R1 held", held_time, 24'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 0, 0);
    step(0, 0, 1, 0);
    for (int i = 0; i < 3599; i++) step(0, 1, 1, 0);
    check("R4 R9 at 00:59:59", live_time, 24'h005959);
    step(0, 1, 1, 0);
    check("R4 R9 at 01:00:00", live_time, 24'h010000);
    for (int i = 0; i < 2 * 3600 - 1; i++) step(0, 1, 1, 0);
    check("R5 at max", live_time, 24'h025959);
    step(0, 1, 1, 0);
    check("R5 wrap", live_time, 24'h000000);
    for (int i = 0; i < 75; i++) step(0, 1, 1, 0);
    step(0, 1, 1, 1);
    check("R6 capture", held_time, 24'h000116);
    for (int i = 0; i < 20; i++) step(0, 1, 1, (i % 5) == 0);
    check("R7 held stays", held_time, 24'h000116);
    check("R7 live runs", live_time, 24'h000136);
    step(1, 1, 1, 1);
    step(0, 1, 1, 0);
    check("R8 release", held_time, 24'h000001);
    for (int i = 0; i < 4000; i++)
      step(($urandom % 200) == 0, ($urandom % 4) != 0, ($urandom % 2) == 0,
           ($urandom % 60) == 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule